// File: doc/BRIEF.md
# Multi-Lane Pseudo-Random Bit Sequence Link Tester

This block measures the bit error quality of a serial link while the link is held out of service. For each lane it has a transmit-side pseudo-random generator and a receive-side checker that synchronizes itself to the incoming bits. While a test runs, the generators drive the lane outputs in place of normal traffic. Each checker counts the bits that disagree with the sequence and holds the count in a three-bit counter that stops at seven.

Software or a link controller picks the lanes to test with a mask, picks one of two polynomials, and sets the test length in bit times. It then pulses a start request. The block raises busy for the programmed number of bit times and pulses done once as busy falls. The per-lane counts then stay readable until the next test starts, so the caller can decide whether to restart the link, narrow it, or move to a spare path.

Top module: `prbs_lane_tester`

## Requirements
- R1: While busy_o is low, tx_bits_o equals link_tx_i bit for bit.
- R2: When start_i is high and busy_o is low at a clock edge, the test is accepted. From the next cycle busy_o is high and every lane count in err_cnt_o is zero. Lane i's count sits in err_cnt_o[3i+2:3i].
- R3: An accepted test keeps busy_o high for exactly period_i clock cycles, with a value of 0 treated as 1. In the first cycle after the last busy cycle, done_o is high for exactly one cycle.
- R4: A start_i pulse while busy_o is high is ignored. The running test keeps its length and its counts.
- R5: The lane mask and polynomial select are captured when a test is accepted, and later changes to those inputs do not affect the test. Select 0 uses x^7+x^6+1 and select 1 uses x^31+x^28+1. A 31-bit state s starts as all ones. In each busy cycle the lane outputs b = s[6]^s[5] (select 0) or b = s[30]^s[27] (select 1), and then s becomes {s[29:0], b}.
- R6: During a test, an enabled lane (mask bit 1) drives its generator bit. A disabled lane drives 0, and its count stays 0 whatever it receives.
- R7: For the first L busy cycles of a test, each checker only loads received bits, with L = 7 for select 0 and 31 for select 1. After that, each received bit that differs from the recurrence applied to the previously received bits adds one error. A single flipped bit therefore gives three errors.
- R8: A lane count saturates at 7 and never wraps.
- R9: After done_o, the counts hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-time clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Test start request |
| lane_en_i | input | NUM_LANES | Lane test mask |
| poly_sel_i | input | 1 | Polynomial select |
| period_i | input | PERIOD_W | Test length in bit times |
| link_tx_i | input | NUM_LANES | Normal traffic bits |
| rx_bits_i | input | NUM_LANES | Received lane bits |
| tx_bits_o | output | NUM_LANES | Lane transmit bits |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_cnt_o | output | 3*NUM_LANES | Saturating per-lane error counts |

## Verification
The bench aims at the sync window by flipping one bit after lock, which must give exactly three errors. A checker that compared during its fill, or one that used the wrong taps, would report a different number. It also inverts a whole lane so the count must stop at seven; a counter that wraps would show a small number instead. A second start while busy and a polynomial change part-way through a test check that the configuration is captured once. A design that reloaded either would stretch the test or break the reference sequence. The bench also checks masked lanes, which must stay at zero and drive 0, and it checks the exact busy length, where an off-by-one counter shows up directly.

// File: rtl/prbs_tester_pkg.sv
package prbs_tester_pkg;

    localparam int unsigned LFSR_W  = 31;
    localparam int unsigned ERR_W   = 3;
    localparam int unsigned FILL_W  = 5;
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    typedef enum logic {
        POLY_SHORT = 1'b0,
        POLY_LONG  = 1'b1
    } poly_e;

    // feedback bit; s[0] holds the most recent bit
    function automatic logic prbs_next(input logic [LFSR_W-1:0] s, input poly_e p);
        logic b;
        if (p == POLY_SHORT) b = s[6] ^ s[5];
        else                 b = s[30] ^ s[27];
        return b;
    endfunction

    function automatic logic [FILL_W-1:0] prbs_len(input poly_e p);
        logic [FILL_W-1:0] n;
        if (p == POLY_SHORT) n = FILL_W'(7);
        else                 n = FILL_W'(31);
        return n;
    endfunction

endpackage

// File: rtl/prbs_period_ctrl.sv
module prbs_period_ctrl
    import prbs_tester_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned PERIOD_W  = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [NUM_LANES-1:0] lane_en_i,
    input  logic                 poly_sel_i,
    input  logic [PERIOD_W-1:0]  period_i,
    output logic                 accept_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [NUM_LANES-1:0] mask_o,
    output poly_e                poly_o
);

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic [PERIOD_W-1:0]  left;
        logic [NUM_LANES-1:0] mask;
        poly_e                poly;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  accept;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = start_i && !st_q.busy;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.left = (period_i == '0) ? PERIOD_W'(1) : period_i;
            st_d.mask = lane_en_i;
            st_d.poly = poly_e'(poly_sel_i);
        end else if (st_q.busy) begin
            if (st_q.left <= PERIOD_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.left = '0;
            end else begin
                st_d.left = st_q.left - PERIOD_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{busy: 1'b0, done: 1'b0, left: '0, mask: '0, poly: POLY_SHORT};
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o = accept;
    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign mask_o   = st_q.mask;
    assign poly_o   = st_q.poly;

endmodule

// File: rtl/prbs_lane_gen.sv
module prbs_lane_gen
    import prbs_tester_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  seed_i,
    input  logic  step_i,
    input  poly_e poly_i,
    output logic  bit_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } gen_t;

    gen_t st_d, st_q;
    logic fb;

    always_comb begin
        st_d = st_q;
        fb   = prbs_next(st_q.lfsr, poly_i);
        if (seed_i) begin
            st_d.lfsr = '1;
        end else if (step_i) begin
            st_d.lfsr = {st_q.lfsr[LFSR_W-2:0], fb};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{lfsr: '1};
        else         st_q <= st_d;
    end

    assign bit_o = fb;

endmodule

// File: rtl/prbs_lane_chk.sv
module prbs_lane_chk
    import prbs_tester_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             active_i,
    input  poly_e            poly_i,
    input  logic             rx_i,
    output logic [ERR_W-1:0] err_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] hist;
        logic [FILL_W-1:0] fill;
        logic [ERR_W-1:0]  errs;
    } chk_t;

    chk_t st_d, st_q;
    logic expect_bit;
    logic locked;

    always_comb begin
        st_d       = st_q;
        expect_bit = prbs_next(st_q.hist, poly_i);
        locked     = (st_q.fill >= prbs_len(poly_i));
        if (clear_i) begin
            st_d = '{hist: '0, fill: '0, errs: '0};
        end else if (active_i) begin
            st_d.hist = {st_q.hist[LFSR_W-2:0], rx_i};
            if (!locked) begin
                st_d.fill = st_q.fill + FILL_W'(1);
            end else if ((rx_i != expect_bit) && (st_q.errs != ERR_MAX)) begin
                st_d.errs = st_q.errs + ERR_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{hist: '0, fill: '0, errs: '0};
        else         st_q <= st_d;
    end

    assign err_o = st_q.errs;

endmodule

// File: rtl/prbs_lane_tester.sv
module prbs_lane_tester
    import prbs_tester_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned PERIOD_W  = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic [NUM_LANES-1:0]       lane_en_i,
    input  logic                       poly_sel_i,
    input  logic [PERIOD_W-1:0]        period_i,
    input  logic [NUM_LANES-1:0]       link_tx_i,
    input  logic [NUM_LANES-1:0]       rx_bits_i,
    output logic [NUM_LANES-1:0]       tx_bits_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [ERR_W*NUM_LANES-1:0] err_cnt_o
);

    logic                 accept;
    logic                 busy;
    logic                 done;
    logic [NUM_LANES-1:0] mask;
    poly_e                poly;

    prbs_period_ctrl #(
        .NUM_LANES (NUM_LANES),
        .PERIOD_W  (PERIOD_W)
    ) ctrl_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .lane_en_i  (lane_en_i),
        .poly_sel_i (poly_sel_i),
        .period_i   (period_i),
        .accept_o   (accept),
        .busy_o     (busy),
        .done_o     (done),
        .mask_o     (mask),
        .poly_o     (poly)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic gen_bit;
        logic lane_on;

        assign lane_on = busy && mask[g];

        prbs_lane_gen gen_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .seed_i (accept),
            .step_i (lane_on),
            .poly_i (poly),
            .bit_o  (gen_bit)
        );

        prbs_lane_chk chk_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clear_i  (accept),
            .active_i (lane_on),
            .poly_i   (poly),
            .rx_i     (rx_bits_i[g]),
            .err_o    (err_cnt_o[g*ERR_W +: ERR_W])
        );

        // test traffic replaces link traffic; masked lanes stay quiet
        always_comb begin
            if (!busy)        tx_bits_o[g] = link_tx_i[g];
            else if (mask[g]) tx_bits_o[g] = gen_bit;
            else              tx_bits_o[g] = 1'b0;
        end
    end

    assign busy_o = busy;
    assign done_o = done;

endmodule

// File: rtl/prbs_lane_tester_chk.sv
module prbs_lane_tester_chk #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned PERIOD_W  = 16
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   start_i,
    input logic [NUM_LANES-1:0]   link_tx_i,
    input logic [NUM_LANES-1:0]   tx_bits_o,
    input logic                   busy_o,
    input logic                   done_o,
    input logic [3*NUM_LANES-1:0] err_cnt_o
);

    // R1
    idle_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> tx_bits_o == link_tx_i);

    // R2
    start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && err_cnt_o == '0));

    // R3
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R3
    done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    // R4
    busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (busy_o || done_o));

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // R8
        err_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(start_i && !busy_o) |=> err_cnt_o[3*g +: 3] >= $past(err_cnt_o[3*g +: 3]));

        // R9
        err_hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!busy_o && !start_i) |=> $stable(err_cnt_o[3*g +: 3]));
    end

endmodule

bind prbs_lane_tester prbs_lane_tester_chk #(
    .NUM_LANES (NUM_LANES),
    .PERIOD_W  (PERIOD_W)
) chk_bind_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .link_tx_i (link_tx_i),
    .tx_bits_o (tx_bits_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_cnt_o (err_cnt_o)
);

// File: tb/prbs_lane_tester_tb.sv
`timescale 1ns/1ps
module prbs_lane_tester_tb_top;

    localparam int NL = 4;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NL-1:0] lane_en = '0;
    logic          poly_sel = 1'b0;
    logic [PW-1:0] period = '0;
    logic [NL-1:0] link_tx = '0;
    logic [NL-1:0] rx_bits;
    logic [NL-1:0] tx_bits;
    logic          busy;
    logic          done;
    logic [3*NL-1:0] err_cnt;

    logic [NL-1:0] inv_mask = '0;
    logic [NL-1:0] inj_mask = '0;
    logic          inj = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign rx_bits = tx_bits ^ inv_mask ^ (inj ? inj_mask : '0);

    prbs_lane_tester #(.NUM_LANES(NL), .PERIOD_W(PW)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .lane_en_i  (lane_en),
        .poly_sel_i (poly_sel),
        .period_i   (period),
        .link_tx_i  (link_tx),
        .rx_bits_i  (rx_bits),
        .tx_bits_o  (tx_bits),
        .busy_o     (busy),
        .done_o     (done),
        .err_cnt_o  (err_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane_err(input int i);
        return int'(err_cnt[3*i +: 3]);
    endfunction

    // runs one test; models lane 0 sequence per R5, flips poly input mid-test
    task automatic run_test(input logic [NL-1:0] mask, input logic psel, input int per,
                            input int inj_at, input int restart_at, output int busy_cycles);
        logic [30:0] ref_s = '1;
        int tx_bad = 0;
        int quiet_bad = 0;
        int k = 1;
        logic b;
        @(negedge clk);
        lane_en = mask; poly_sel = psel; period = PW'(per); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            inj = (k == inj_at);
            if (k == 3) begin
                poly_sel = ~psel;
                lane_en = ~mask;
            end
            if (k == restart_at) begin
                period = PW'(5);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            b = psel ? (ref_s[30] ^ ref_s[27]) : (ref_s[6] ^ ref_s[5]);
            ref_s = {ref_s[29:0], b};
            if (mask[0] && tx_bits[0] != b) tx_bad++;
            for (int i = 0; i < NL; i++)
                if (!mask[i] && tx_bits[i] != 1'b0) quiet_bad++;
            @(negedge clk);
            k++;
        end
        inj = 1'b0;
        start = 1'b0;
        busy_cycles = k - 1;
        check("R5 lane0 sequence mismatches", tx_bad, 0);
        check("R6 disabled lane tx nonzero", quiet_bad, 0);
        check("R3 done after busy", int'(done), 1);
        @(negedge clk);
        check("R3 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset_idle();
        check("R2 reset busy", int'(busy), 0);
        check("R3 reset done", int'(done), 0);
        check("R2 reset counts", int'(err_cnt), 0);
        link_tx = 4'b1010;
        #1;
        check("R1 passthrough a", int'(tx_bits), 'hA);
        link_tx = 4'b0111;
        #1;
        check("R1 passthrough b", int'(tx_bits), 'h7);
    endtask

    task automatic t_loopback(input logic psel, input int per);
        int bc;
        run_test(4'hF, psel, per, -1, -1, bc);
        check("R3 busy length", bc, per);
        for (int i = 0; i < NL; i++) check("R7 loopback no errors", lane_err(i), 0);
    endtask

    task automatic t_saturate();
        int bc;
        inv_mask = 4'b0100;
        run_test(4'hF, 1'b0, 100, -1, -1, bc);
        inv_mask = '0;
        check("R8 inverted lane saturates", lane_err(2), 7);
        check("R8 other lane clean", lane_err(0), 0);
        repeat (5) @(negedge clk);
        check("R9 counts held", lane_err(2), 7);
    endtask

    task automatic t_start_clears();
        @(negedge clk);
        lane_en = 4'hF; poly_sel = 1'b0; period = PW'(50); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 counts cleared on start", int'(err_cnt), 0);
        check("R2 busy after start", int'(busy), 1);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_single_flip(input logic psel, input int per, input int at);
        int bc;
        inj_mask = 4'b0010;
        run_test(4'hF, psel, per, at, -1, bc);
        inj_mask = '0;
        check("R7 single flip gives three", lane_err(1), 3);
        check("R7 neighbour lane clean", lane_err(3), 0);
    endtask

    task automatic t_mask();
        int bc;
        inv_mask = 4'b1000;
        run_test(4'b0010, 1'b0, 60, -1, -1, bc);
        inv_mask = '0;
        check("R6 masked lane count", lane_err(3), 0);
        check("R6 enabled lane clean", lane_err(1), 0);
    endtask

    task automatic t_restart_ignored();
        int bc;
        run_test(4'hF, 1'b0, 80, -1, 20, bc);
        check("R4 start while busy ignored", bc, 80);
        check("R4 counts kept", lane_err(0), 0);
    endtask

    task automatic t_zero_period();
        int bc;
        run_test(4'hF, 1'b0, 0, -1, -1, bc);
        check("R3 zero period runs one cycle", bc, 1);
    endtask

    initial begin
        #200_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_idle();
        rst_n = 1'b1;
        @(negedge clk);
        t_loopback(1'b0, 100);
        t_loopback(1'b1, 200);
        t_saturate();
        t_start_clears();
        t_single_flip(1'b0, 100, 50);
        t_single_flip(1'b1, 150, 60);
        t_mask();
        t_restart_ignored();
        t_zero_period();
        link_tx = 4'b0101;
        #1;
        check("R1 passthrough after tests", int'(tx_bits), 'h5);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule